// File: doc/BRIEF.md
# Per-Core Banked Timer Array

This block holds a pair of down-counting timers for each core of a small cluster of one to four cores. The first timer of each pair is the core's general timer and the second is its watchdog-style timer. Both have the same register set. The register sets are reached through a row of equal 32-byte windows on a simple request port. Each window holds four word registers.

The first two windows are banked. Window 0 reaches the general timer of the core that makes the request, and window 1 reaches that core's watchdog. The core is identified by a core-ID input. All later windows are fixed: they name one timer of one core, whichever core makes the access. A banked access and the matching fixed access reach the same storage.

Each timer drives one interrupt line while its status flag is set. The interrupt lines are packed into one vector in a fixed per-core order. The core count is a parameter, and the design refuses to elaborate with a count outside one to four.

Top module: `bta_top`

## Requirements
- R1: After reset every timer's reload, count, control and status read as zero and every interrupt line is low.
- R2: Fixed window 2+2i reaches timer instance 2i, which is the general timer of core i. Fixed window 3+2i reaches instance 2i+1, which is the watchdog of core i. The window number is address bits [8:5].
- R3: Window 0 reaches instance 2*reqCore and window 1 reaches instance 2*reqCore+1. A write through one of these banked windows has exactly the effect of the same write through the matching fixed window.
- R4: A request to window 0 or 1 whose reqCore is at or above the core count is an error. Such a write changes nothing, a read returns zero, and accErr is high for the single cycle after the request. Fixed windows do not check reqCore.
- R5: A request whose reqByteEn is not 4'hF is an error with the same handling as in R4.
- R6: A window number at or above 2+2N, or a word offset of 0x10 to 0x1C inside a window, reads as zero, ignores writes and raises no error.
- R7: The registers sit at word offsets inside a window: 0x00 is the reload value, and writing it also loads the count; 0x04 is the count; 0x08 is the control register, where bit 0 enables counting and bit 1 selects periodic mode; 0x0C is the status register, whose bit 0 is cleared by writing a 1 there.
- R8: While a timer is enabled and its count is nonzero, the count drops by one every cycle. The step from 1 sets the status flag. After that step the count becomes the reload value in periodic mode, or stays at zero otherwise.
- R9: A control write that turns enable on from off, while the count is zero and periodic mode is being selected, copies the reload value into the count.
- R10: irqOut[k] equals the status flag of instance k. The vector therefore runs core 0 general timer, core 0 watchdog, core 1 general timer, and so on.
- R11: When a status-clear write lands in the same cycle as an expiry of that timer, the status flag remains set.
- R12: Read data and rspValid appear in the cycle after a read request. After a write, rspValid is low and rspData is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqAddr | input | ADDR_W (9) | Byte address: window in [8:5], word in [4:2] |
| reqWdata | input | 32 | Write data |
| reqByteEn | input | 4 | Byte enables; must be all ones |
| reqCore | input | 2 | ID of the requesting core |
| rspData | output | 32 | Read data, one cycle after the request |
| rspValid | output | 1 | Marks a read response |
| accErr | output | 1 | One-cycle error pulse |
| irqOut | output | 2*NUM_CORES | Per-instance interrupt lines |

## Verification
Two events can fall in the same cycle: a timer's own expiry and a status-clear write to that timer. The bench runs a periodic timer with a short reload and counts cycles from the enabling write. It then lands the clear request exactly on the second expiry edge and expects the interrupt to stay high. It issues one more clear on a later edge and expects the line to fall, which shows that the clear path works on its own.

// File: rtl/bta_pkg.sv
package bta_pkg;
  localparam int CORE_W = 2;
  localparam int INST_W = CORE_W + 1;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_STAT   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic              wrHit;
    logic              rdHit;
    logic              rdReq;
    logic [INST_W-1:0] inst;
    regSel_e           regSel;
  } strobe_t;
endpackage

// File: rtl/bta_timer.sv
module bta_timer
  import bta_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  regSel_e           regSel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdWord,
  output logic              irq
);
  logic [DATA_W-1:0] reloadQ;
  logic [DATA_W-1:0] cntQ;
  logic              enQ;
  logic              periodicQ;
  logic              statQ;
  logic              cntTouched;
  logic              expire;
  logic              clrReq;

  always_comb begin
    cntTouched = wrEn && (regSel != REG_STAT);
    expire     = enQ && (cntQ == DATA_W'(1)) && !cntTouched;
    clrReq     = wrEn && (regSel == REG_STAT) && wdata[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ   <= '0;
      cntQ      <= '0;
      enQ       <= 1'b0;
      periodicQ <= 1'b0;
      statQ     <= 1'b0;
    end else begin
      if (wrEn && regSel == REG_RELOAD) begin
        reloadQ <= wdata;
        cntQ    <= wdata;
      end else if (wrEn && regSel == REG_COUNT) begin
        cntQ <= wdata;
      end else if (wrEn && regSel == REG_CTRL) begin
        enQ       <= wdata[0];
        periodicQ <= wdata[1];
        if (!enQ && wdata[0] && wdata[1] && cntQ == '0) cntQ <= reloadQ;
      end else if (enQ && cntQ != '0) begin
        if (cntQ == DATA_W'(1)) cntQ <= periodicQ ? reloadQ : '0;
        else                    cntQ <= cntQ - DATA_W'(1);
      end
      statQ <= (statQ && !clrReq) || expire;
    end
  end

  always_comb begin
    case (regSel)
      REG_RELOAD: rdWord = reloadQ;
      REG_COUNT:  rdWord = cntQ;
      REG_CTRL:   rdWord = {{(DATA_W-2){1'b0}}, periodicQ, enQ};
      default:    rdWord = {{(DATA_W-1){1'b0}}, statQ};
    endcase
  end

  assign irq = statQ;
endmodule

// File: rtl/bta_ctrl.sv
module bta_ctrl
  import bta_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqByteEn,
  input  logic [CORE_W-1:0] reqCore,
  output strobe_t           stb,
  output logic              accErr
);
  localparam int WIN_W   = ADDR_W - 5;
  localparam int NUM_WIN = 2 + 2 * NUM_CORES;

  logic [WIN_W-1:0] win;
  logic [WIN_W-1:0] winOff;
  logic             isAlias;
  logic             badCore;
  logic             badSize;
  logic             errNow;
  logic             hit;

  always_comb begin
    win     = reqAddr[ADDR_W-1:5];
    winOff  = win - WIN_W'(2);
    isAlias = (win < WIN_W'(2));
    badCore = isAlias && ({1'b0, reqCore} >= INST_W'(NUM_CORES));
    badSize = (reqByteEn != 4'hF);
    errNow  = reqValid && (badCore || badSize);
    hit     = reqValid && !errNow && (win < WIN_W'(NUM_WIN)) && !reqAddr[4];

    stb.wrHit  = hit && reqWrite;
    stb.rdHit  = hit && !reqWrite;
    stb.rdReq  = reqValid && !reqWrite;
    stb.inst   = isAlias ? {reqCore, win[0]} : winOff[INST_W-1:0];
    stb.regSel = regSel_e'(reqAddr[3:2]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) accErr <= 1'b0;
    else       accErr <= errNow;
  end
endmodule

// File: rtl/bta_datapath.sv
module bta_datapath
  import bta_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                stb,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rspData,
  output logic                   rspValid,
  output logic [2*NUM_CORES-1:0] irqOut
);
  localparam int NUM_INST = 2 * NUM_CORES;
  localparam int SLOTS    = 1 << INST_W;

  logic [DATA_W-1:0] slotWord [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NUM_INST) begin : g_live
      bta_timer #(.DATA_W(DATA_W)) u_timer (
        .clk    (clk),
        .rstN   (rstN),
        .wrEn   (stb.wrHit && (stb.inst == INST_W'(g))),
        .regSel (stb.regSel),
        .wdata  (wdata),
        .rdWord (slotWord[g]),
        .irq    (irqOut[g])
      );
    end else begin : g_empty
      assign slotWord[g] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspData  <= '0;
      rspValid <= 1'b0;
    end else begin
      rspData  <= stb.rdHit ? slotWord[stb.inst] : '0;
      rspValid <= stb.rdReq;
    end
  end
endmodule

// File: rtl/bta_top.sv
module bta_top
  import bta_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 9
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [31:0]            reqWdata,
  input  logic [3:0]             reqByteEn,
  input  logic [CORE_W-1:0]      reqCore,
  output logic [31:0]            rspData,
  output logic                   rspValid,
  output logic                   accErr,
  output logic [2*NUM_CORES-1:0] irqOut
);
  if (NUM_CORES < 1 || NUM_CORES > 4) begin : g_badCoreCount
    $error("bta_top: NUM_CORES must lie between 1 and 4");
  end

  strobe_t stb;

  bta_ctrl #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqByteEn (reqByteEn),
    .reqCore   (reqCore),
    .stb       (stb),
    .accErr    (accErr)
  );

  bta_datapath #(.NUM_CORES(NUM_CORES), .DATA_W(32)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wdata    (reqWdata),
    .rspData  (rspData),
    .rspValid (rspValid),
    .irqOut   (irqOut)
  );
endmodule

// File: rtl/bta_checker.sv
module bta_checker
  import bta_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 9
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic                   reqWrite,
  input logic [ADDR_W-1:0]      reqAddr,
  input logic [31:0]            reqWdata,
  input logic [3:0]             reqByteEn,
  input logic [CORE_W-1:0]      reqCore,
  input logic [31:0]            rspData,
  input logic                   rspValid,
  input logic                   accErr,
  input logic [2*NUM_CORES-1:0] irqOut
);
  localparam int WIN_W   = ADDR_W - 5;
  localparam int NUM_WIN = 2 + 2 * NUM_CORES;

  logic [WIN_W-1:0] chkWin;
  logic             chkBadCore;
  assign chkWin     = reqAddr[ADDR_W-1:5];
  assign chkBadCore = (chkWin < WIN_W'(2)) && ({1'b0, reqCore} >= INST_W'(NUM_CORES));

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> $past(reqValid)) else $error("accErr without request"); // R4

  AST_BAD_CORE_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && chkBadCore |=> accErr && rspData == 32'd0) else $error("bad core not flagged"); // R4

  AST_PARTIAL_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqByteEn != 4'hF |=> accErr && rspData == 32'd0) else $error("partial access not flagged"); // R5

  AST_OUT_OF_RANGE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqByteEn == 4'hF && chkWin >= WIN_W'(NUM_WIN) |=> !accErr && rspData == 32'd0)
    else $error("out-of-range window misbehaved"); // R6

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqWrite |=> rspValid) else $error("read without response"); // R12

  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqWrite |=> !rspValid && rspData == 32'd0) else $error("write produced response"); // R12
endmodule

bind bta_top bta_checker #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/bta_top_test.sv
module bta_top_test;
  localparam int NC = 3;
  localparam int NI = 2 * NC;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [8:0]    reqAddr = '0;
  logic [31:0]   reqWdata = '0;
  logic [3:0]    reqByteEn = 4'hF;
  logic [1:0]    reqCore = '0;
  logic [31:0]   rspData;
  logic          rspValid;
  logic          accErr;
  logic [NI-1:0] irqOut;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  bta_top #(.NUM_CORES(NC), .ADDR_W(9)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqByteEn(reqByteEn),
    .reqCore(reqCore), .rspData(rspData), .rspValid(rspValid),
    .accErr(accErr), .irqOut(irqOut)
  );

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic expect32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a negedge; the request is captured at the next posedge,
  // and the task returns at the following negedge with the response visible.
  task automatic busOp(input logic wr, input int win, input int wordIdx,
                       input logic [31:0] data, input logic [1:0] core, input logic [3:0] be);
    reqValid  = 1'b1;
    reqWrite  = wr;
    reqAddr   = 9'(win * 32 + wordIdx * 4);
    reqWdata  = data;
    reqCore   = core;
    reqByteEn = be;
    @(negedge clk);
    reqValid  = 1'b0;
    reqWrite  = 1'b0;
    reqByteEn = 4'hF;
  endtask

  task automatic wrReg(input int win, input int wordIdx, input logic [31:0] data, input logic [1:0] core);
    busOp(1'b1, win, wordIdx, data, core, 4'hF);
  endtask

  task automatic rdReg(input int win, input int wordIdx, input logic [1:0] core, output logic [31:0] val);
    busOp(1'b0, win, wordIdx, 32'd0, core, 4'hF);
    val = rspData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tReset();
    logic [31:0] v;
    expect32("R1 irq after reset", 32'(irqOut), 32'd0);
    for (int w = 2; w < 2 + NI; w++) begin
      for (int r = 0; r < 4; r++) begin
        rdReg(w, r, 2'd0, v);
        expect32($sformatf("R1 win %0d reg %0d after reset", w, r), v, 32'd0);
      end
    end
  endtask

  task automatic tFixedAndAlias();
    logic [31:0] v;
    for (int w = 2; w < 2 + NI; w++) wrReg(w, 0, 32'h100 + 32'(w), 2'd0);
    for (int c = 0; c < NC; c++) begin
      rdReg(0, 0, 2'(c), v);
      expect32($sformatf("R2/R3 core %0d timer via bank", c), v, 32'h100 + 32'(2 + 2*c));
      expect32("R12 rspValid on read", 32'(rspValid), 32'd1);
      rdReg(1, 0, 2'(c), v);
      expect32($sformatf("R2/R3 core %0d watchdog via bank", c), v, 32'h100 + 32'(3 + 2*c));
    end
    wrReg(1, 1, 32'hABC, 2'd2);
    expect32("R12 rspValid after write", 32'(rspValid), 32'd0);
    expect32("R12 rspData after write", rspData, 32'd0);
    rdReg(7, 1, 2'd0, v);
    expect32("R3 banked count write seen in fixed window", v, 32'hABC);
    rdReg(7, 0, 2'd0, v);
    expect32("R3 reload untouched by count write", v, 32'h107);
    rdReg(6, 1, 2'd0, v);
    expect32("R3 neighbour untouched", v, 32'h106);
  endtask

  task automatic tBadCore();
    logic [31:0] v;
    busOp(1'b1, 0, 1, 32'hDEAD, 2'd3, 4'hF);
    expect32("R4 accErr on bad core write", 32'(accErr), 32'd1);
    @(negedge clk);
    expect32("R4 accErr lasts one cycle", 32'(accErr), 32'd0);
    busOp(1'b0, 1, 0, 32'd0, 2'd3, 4'hF);
    expect32("R4 bad core read data", rspData, 32'd0);
    expect32("R4 accErr on bad core read", 32'(accErr), 32'd1);
    for (int w = 2; w < 2 + NI; w++) begin
      rdReg(w, 1, 2'd0, v);
      expect32($sformatf("R4 win %0d count unchanged", w), v, (w == 7) ? 32'hABC : 32'h100 + 32'(w));
    end
    rdReg(2, 0, 2'd3, v);
    expect32("R4 fixed window ignores core id", v, 32'h102);
    expect32("R4 no error on fixed window", 32'(accErr), 32'd0);
  endtask

  task automatic tPartial();
    logic [31:0] v;
    busOp(1'b1, 4, 0, 32'h5555, 2'd0, 4'h3);
    expect32("R5 accErr on partial write", 32'(accErr), 32'd1);
    busOp(1'b0, 4, 0, 32'd0, 2'd0, 4'h1);
    expect32("R5 partial read data", rspData, 32'd0);
    rdReg(4, 0, 2'd0, v);
    expect32("R5 reload unchanged", v, 32'h104);
  endtask

  task automatic tOutOfRange();
    logic [31:0] v;
    wrReg(8, 0, 32'h77, 2'd0);
    expect32("R6 no error out of range", 32'(accErr), 32'd0);
    rdReg(8, 0, 2'd0, v);
    expect32("R6 out-of-range window reads zero", v, 32'd0);
    wrReg(2, 4, 32'h99, 2'd0);
    rdReg(2, 4, 2'd0, v);
    expect32("R6 upper half of window reads zero", v, 32'd0);
    rdReg(2, 0, 2'd0, v);
    expect32("R6 reload not hit by upper-half write", v, 32'h102);
    rdReg(2, 1, 2'd0, v);
    expect32("R6 count not hit by upper-half write", v, 32'h102);
  endtask

  task automatic tOneShot();
    logic [31:0] v;
    wrReg(5, 0, 32'd5, 2'd0);
    wrReg(5, 2, 32'd1, 2'd0);
    idle(4);
    expect32("R8 no expiry before count ends", 32'(irqOut), 32'd0);
    idle(1);
    expect32("R8/R10 core 1 watchdog irq bit 3", 32'(irqOut), 32'h8);
    rdReg(5, 1, 2'd0, v);
    expect32("R8 one-shot stays at zero", v, 32'd0);
    rdReg(5, 2, 2'd0, v);
    expect32("R7 control readback", v, 32'd1);
    rdReg(5, 3, 2'd0, v);
    expect32("R7 status readback", v, 32'd1);
    wrReg(5, 3, 32'd1, 2'd0);
    expect32("R7 status write-one clears", 32'(irqOut), 32'd0);
    wrReg(5, 2, 32'd0, 2'd0);
  endtask

  task automatic tPeriodicCollision();
    logic [31:0] v;
    wrReg(6, 0, 32'd3, 2'd0);
    wrReg(6, 2, 32'd3, 2'd0);
    idle(3);
    expect32("R8/R10 core 2 timer irq bit 4", 32'(irqOut), 32'h10);
    rdReg(6, 1, 2'd0, v);
    expect32("R8 periodic reload after expiry", v, 32'd3);
    idle(1);
    wrReg(6, 3, 32'd1, 2'd0);
    expect32("R11 clear on expiry cycle keeps status", 32'(irqOut), 32'h10);
    wrReg(6, 3, 32'd1, 2'd0);
    expect32("R11 clear away from expiry drops irq", 32'(irqOut), 32'd0);
    wrReg(6, 2, 32'd0, 2'd0);
  endtask

  task automatic tEnableLoad();
    logic [31:0] v;
    wrReg(2, 0, 32'd7, 2'd0);
    wrReg(2, 1, 32'd0, 2'd0);
    wrReg(2, 2, 32'd3, 2'd0);
    rdReg(2, 1, 2'd0, v);
    expect32("R9 enable with zero count loads reload", v, 32'd7);
    wrReg(2, 2, 32'd0, 2'd0);
    wrReg(3, 1, 32'd0, 2'd0);
    wrReg(3, 2, 32'd1, 2'd0);
    idle(3);
    rdReg(3, 1, 2'd0, v);
    expect32("R9 one-shot enable keeps zero count", v, 32'd0);
    expect32("R9 no irq from zero count", 32'(irqOut), 32'd0);
    wrReg(3, 2, 32'd0, 2'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle(4);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tFixedAndAlias();
    tBadCore();
    tPartial();
    tOutOfRange();
    tOneShot();
    tPeriodicCollision();
    tEnableLoad();
    finishRun();
  end
endmodule